// File: doc/BRIEF.md
# Serial EEPROM controller with boot-time image load

This block drives a three-wire serial EEPROM organised as 128 bytes: a chip select, a shift clock, a data line out to the device and a data line back from it. Coming out of reset it reads location 0 of the EEPROM. If that byte is the signature 0xA5, it copies every EEPROM location into an internal 512-byte memory. If the byte is anything else, the load stops after that one frame. A hold output keeps the upstream link disconnected until the load is over, whether the load succeeded or was abandoned. Other logic reads the loaded image through a registered read port.

Once the load is done, a host runs single commands through a command strobe and a data register. It loads the data register first when a write needs data. It then writes the command fields together with the start bit. The busy output rises and stays high until the frame has been shifted out. For erase and write commands it also stays high while the controller waits for the device to report ready. If the device never reports ready within the configured number of milliseconds, the command is abandoned and the timeout flag is raised.

Each frame begins with a start bit of 1. A 2-bit opcode follows (10 read, 01 write, 11 erase, 00 special), then the 7-bit address. Write data or read data, when present, follows as 8 bits. All fields go MSB first.

Top module: `mw_eeprom_ctl`

## Requirements
- R1: From reset until the load sequence ends, `link_hold` and `busy` are 1. During reset `eecs`, `eesk` and `timeout` are 0 and `data_q` is 0x00. Once `link_hold` falls it stays 0 until the next reset.
- R2: The load reads address 0 first. If that byte is 0xA5, the controller copies EEPROM locations 0 to 127 into memory locations 0 to 127. It uses one read frame per location, which makes 128 chip-select pulses in total.
- R3: If the byte at address 0 is not 0xA5, the load ends after that single frame and nothing is written to the memory.
- R4: `mem_rdata` shows the memory byte at `mem_raddr` one clock after the address is applied.
- R5: A frame starts with `eecs` rising. `eedi` changes only while `eesk` is low, and the device samples it on the rising edge of `eesk`. The frame is a start bit 1, a 2-bit opcode, a 7-bit address and then 8 data bits when the command carries data, all MSB first. Outside a frame or the ready poll, `eecs` and `eesk` are 0.
- R6: When `busy` is 0, a pulse on `cmd_wr` with `cmd_start`=1 starts the command and raises `busy` on the next clock. The `cmd_op` codes are 0 READ, 1 WRITE, 2 ERASE, 3 EWEN, 4 EWDS, 5 ERAL and 6 WRAL. Code 7 starts nothing. `busy` clears when the command completes.
- R7: For READ (opcode 10 plus address), 8 data clocks follow the address. The byte returned on `eedo` is in `data_q` when `busy` clears.
- R8: `data_wr` loads `data_q` while `busy` is 0. WRITE (opcode 01 plus address) and WRAL (opcode 00, address prefix 01) shift `data_q` out after the address.
- R9: `cmd_wr` and `data_wr` have no effect while `busy` is 1.
- R10: After an ERASE, WRITE, ERAL or WRAL frame, `eecs` drops for one shift half-period and then rises again. The command completes on the first clock on which `eedo` is 1.
- R11: If `eedo` stays 0 for TIMEOUT_MS*CLKS_PER_MS clocks during the ready poll, `timeout` is set and `busy` clears. The next command start clears `timeout`.
- R12: ERASE is sent as opcode 11 plus address. The special commands are sent with opcode 00 and a 2-bit address prefix: EWEN 11, EWDS 00, ERAL 10, WRAL 01. A device powered up write-disabled therefore accepts writes only after EWEN and ignores them again after EWDS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; starts the load when released |
| eecs | output | 1 | EEPROM chip select |
| eesk | output | 1 | EEPROM shift clock |
| eedi | output | 1 | Serial data to the EEPROM |
| eedo | input | 1 | Serial data and ready level from the EEPROM |
| link_hold | output | 1 | Keeps the upstream link disconnected while loading |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_start | input | 1 | Start bit written with the command |
| cmd_op | input | 3 | Command code |
| cmd_addr | input | 7 | EEPROM location for READ, WRITE and ERASE |
| data_wr | input | 1 | Data register write strobe |
| data_wdata | input | 8 | Value for the data register |
| data_q | output | 8 | Data register |
| busy | output | 1 | Command or load in progress |
| timeout | output | 1 | Last erase or write got no ready level in time |
| mem_raddr | input | 9 | Image memory read address |
| mem_rdata | output | 8 | Image memory read data, one clock later |

## Verification
The embedded assertions check on every cycle that the hold output never returns once released, and that the chip select and shift clock stay low outside frames. They also check that busy rises after the load only in response to a start request, and that the timeout flag rises only at the end of a ready poll and is clear at every command start. Only the bench scenarios, run against an EEPROM model, can show the rest. These are the loaded image and its frame count, the single-frame abort on a wrong signature, the read data and the write-enable sequencing. They also cover the ready wait, the timeout length and the fact that strobes arriving while busy change nothing.

// File: rtl/mw_eeprom_ctl.sv
module mw_eeprom_ctl #(
  parameter int EE_AW       = 7,
  parameter int MEM_AW      = 9,
  parameter int SK_DIV      = 4,
  parameter int CLKS_PER_MS = 25000,
  parameter int TIMEOUT_MS  = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              eecs,
  output logic              eesk,
  output logic              eedi,
  input  logic              eedo,
  output logic              link_hold,
  input  logic              cmd_wr,
  input  logic              cmd_start,
  input  logic [2:0]        cmd_op,
  input  logic [EE_AW-1:0]  cmd_addr,
  input  logic              data_wr,
  input  logic [7:0]        data_wdata,
  output logic [7:0]        data_q,
  output logic              busy,
  output logic              timeout,
  input  logic [MEM_AW-1:0] mem_raddr,
  output logic [7:0]        mem_rdata
);
  localparam int HW  = 3 + EE_AW;
  localparam int FW  = HW + 8;
  localparam int NW  = $clog2(FW + 1);
  localparam int DW  = $clog2(SK_DIV);
  localparam int TMO = CLKS_PER_MS * TIMEOUT_MS;
  localparam int TW  = $clog2(TMO);

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_GAP, S_POLL} st_t;

  st_t              st;
  logic             boot, sig, rd, wt, sk, cs;
  logic [EE_AW-1:0] baddr;
  logic [FW-1:0]    sreg;
  logic [NW-1:0]    nleft;
  logic [DW-1:0]    div;
  logic [TW-1:0]    tcnt;
  logic [7:0]       rx;
  logic [7:0]       mem [2**MEM_AW];

  function automatic logic [FW-1:0] frame(input logic [2:0] op, input logic [EE_AW-1:0] a,
                                          input logic [7:0] d);
    logic [EE_AW-3:0] z;
    z = '0;
    case (op)
      3'd0:    frame = {3'b110, a, 8'h00};
      3'd1:    frame = {3'b101, a, d};
      3'd2:    frame = {3'b111, a, 8'h00};
      3'd3:    frame = {3'b100, 2'b11, z, 8'h00};
      3'd4:    frame = {3'b100, 2'b00, z, 8'h00};
      3'd5:    frame = {3'b100, 2'b10, z, 8'h00};
      default: frame = {3'b100, 2'b01, z, d};
    endcase
  endfunction

  logic             go, gap_end, done, mem_we;
  logic [2:0]       sel_op;
  logic [EE_AW-1:0] sel_a;

  assign busy      = boot || (st != S_IDLE);
  assign link_hold = boot;
  assign eecs      = cs;
  assign eesk      = sk;
  assign eedi      = cs & sreg[FW-1];
  assign go        = !busy && cmd_wr && cmd_start && (cmd_op != 3'd7);
  assign sel_op    = boot ? 3'd0 : cmd_op;
  assign sel_a     = boot ? baddr : cmd_addr;
  assign gap_end   = (st == S_GAP) && (div == DW'(SK_DIV - 1));
  assign done      = (gap_end && !wt) || ((st == S_POLL) && (eedo || tcnt == TW'(TMO - 1)));
  assign mem_we    = done && boot && (!sig || rx == 8'hA5);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; boot <= 1'b1; sig <= 1'b1; baddr <= '0;
      rd <= 1'b0; wt <= 1'b0; sk <= 1'b0; cs <= 1'b0;
      sreg <= '0; nleft <= '0; div <= '0; tcnt <= '0; rx <= '0;
      data_q <= '0; timeout <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (boot || go) begin
          sreg  <= frame(sel_op, sel_a, data_q);
          nleft <= (sel_op == 3'd0 || sel_op == 3'd1 || sel_op == 3'd6) ? NW'(FW) : NW'(HW);
          rd    <= (sel_op == 3'd0);
          wt    <= (sel_op == 3'd1 || sel_op == 3'd2 || sel_op == 3'd5 || sel_op == 3'd6);
          cs    <= 1'b1;
          sk    <= 1'b0;
          div   <= '0;
          st    <= S_SHIFT;
          if (go) timeout <= 1'b0;
        end
        S_SHIFT: if (div == DW'(SK_DIV - 1)) begin
          div <= '0;
          if (!sk) begin
            sk <= 1'b1;
            if (rd && nleft <= NW'(8)) rx <= {rx[6:0], eedo};
          end else begin
            sk    <= 1'b0;
            sreg  <= sreg << 1;
            nleft <= nleft - 1'b1;
            if (nleft == NW'(1)) begin
              cs <= 1'b0;
              st <= S_GAP;
            end
          end
        end else div <= div + 1'b1;
        S_GAP: if (gap_end) begin
          div <= '0;
          if (wt) begin
            cs   <= 1'b1;
            tcnt <= '0;
            st   <= S_POLL;
          end
        end else div <= div + 1'b1;
        S_POLL: if (!done) tcnt <= tcnt + 1'b1;
        else begin
          cs      <= 1'b0;
          timeout <= !eedo;
        end
        default: st <= S_IDLE;
      endcase
      if (done) begin
        st <= S_IDLE;
        if (boot) begin
          if (sig && rx != 8'hA5) boot <= 1'b0;
          else begin
            sig <= 1'b0;
            if (&baddr) boot <= 1'b0;
            else baddr <= baddr + 1'b1;
          end
        end else if (rd) data_q <= rx;
      end
      if (!busy && data_wr) data_q <= data_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem[MEM_AW'(baddr)] <= rx;
    mem_rdata <= mem[mem_raddr];
  end

  p_hold_stays_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !link_hold |=> !link_hold);
  p_pins_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!eecs && !eesk));
  p_sk_needs_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !eecs |-> !eesk);
  p_start_needs_go_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!link_hold && $rose(busy)) |-> $past(cmd_wr && cmd_start && !busy));
  p_timeout_from_poll_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout) |-> ($past(eecs) && !eecs && !busy));
  p_timeout_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !timeout);
endmodule

// File: tb/mw_eeprom_ctl_tb.sv
module mw_eeprom_ctl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DLY = 40;
  localparam int TMO = 10 * 30;

  logic clk = 0, rst_n = 0;
  logic eecs, eesk, eedi, eedo, link_hold, busy, timeout;
  logic cmd_wr = 0, cmd_start = 0, data_wr = 0;
  logic [2:0] cmd_op = 0;
  logic [6:0] cmd_addr = 0;
  logic [7:0] data_wdata = 0, data_q, mem_rdata;
  logic [8:0] mem_raddr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mw_eeprom_ctl #(.EE_AW(7), .MEM_AW(9), .SK_DIV(2), .CLKS_PER_MS(10), .TIMEOUT_MS(30)) dut_i (
    .clk(clk), .rst_n(rst_n), .eecs(eecs), .eesk(eesk), .eedi(eedi), .eedo(eedo),
    .link_hold(link_hold), .cmd_wr(cmd_wr), .cmd_start(cmd_start), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .data_wr(data_wr), .data_wdata(data_wdata), .data_q(data_q),
    .busy(busy), .timeout(timeout), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata));

  // EEPROM model, evaluated on the falling clock edge
  logic [7:0] ee [128];
  logic [7:0] img [128];
  logic [9:0] hdr;
  logic [7:0] wdat, rdat;
  logic en_w = 0, dead = 0, present = 1, rdmode = 0, dbit = 0, sk_p = 0, cs_p = 0;
  int cnt = 0, rtimer = 0, cs_rises = 0;

  assign eedo = !present ? 1'b0 : (eecs && cnt == 0) ? (rtimer == 0 && !dead) : dbit;

  always @(negedge clk) begin
    if (rtimer > 0) rtimer = rtimer - 1;
    if (eecs && !cs_p) cs_rises = cs_rises + 1;
    if (!eecs) begin
      cnt = 0; dbit = 0; rdmode = 0;
    end else if (eesk && !sk_p) begin
      if (cnt < 10) hdr = {hdr[8:0], eedi};
      else if (cnt < 18) wdat = {wdat[6:0], eedi};
      cnt = cnt + 1;
      if (cnt == 10 && hdr[9]) begin
        case (hdr[8:7])
          2'b10: begin rdmode = 1; rdat = ee[hdr[6:0]]; end
          2'b11: if (en_w) begin ee[hdr[6:0]] = 8'hFF; rtimer = DLY; end
          2'b00: case (hdr[6:5])
            2'b11: en_w = 1;
            2'b00: en_w = 0;
            2'b10: if (en_w) begin
              for (int i = 0; i < 128; i++) ee[i] = 8'hFF;
              rtimer = DLY;
            end
            default: ;
          endcase
          default: ;
        endcase
      end
      if (cnt == 18 && hdr[9] && hdr[8:7] == 2'b01 && en_w) begin
        ee[hdr[6:0]] = wdat; rtimer = DLY;
      end
      if (cnt == 18 && hdr[9] && hdr[8:7] == 2'b00 && hdr[6:5] == 2'b01 && en_w) begin
        for (int i = 0; i < 128; i++) ee[i] = wdat;
        rtimer = DLY;
      end
    end else if (!eesk && sk_p && rdmode && cnt >= 10 && cnt < 18) begin
      dbit = rdat[17 - cnt];
    end
    sk_p = eesk;
    cs_p = eecs;
  end

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_idle(output int cyc);
    cyc = 0;
    while (busy && cyc < 2000) begin @(negedge clk); cyc++; end
  endtask

  task automatic run_cmd(input logic [2:0] op, input logic [6:0] a, output int cyc);
    @(negedge clk);
    cmd_wr = 1; cmd_start = 1; cmd_op = op; cmd_addr = a;
    @(negedge clk);
    cmd_wr = 0; cmd_start = 0;
    wait_idle(cyc);
  endtask

  task automatic set_data(input logic [7:0] d);
    @(negedge clk);
    data_wr = 1; data_wdata = d;
    @(negedge clk);
    data_wr = 0;
  endtask

  task automatic read_chk(input logic [6:0] a, input logic [7:0] exp, input string req);
    int c;
    run_cmd(3'd0, a, c);
    chk(data_q == exp, req, data_q, exp);
  endtask

  task automatic reset_and_boot(output int cyc);
    rst_n = 0;
    cs_rises = 0;
    repeat (3) @(negedge clk);
    chk(link_hold && busy && !eecs && !eesk && !timeout && data_q == 8'h00, "R1 reset state",
        {link_hold, busy, eecs, eesk, timeout}, 5'b11000);
    rst_n = 1;
    cyc = 0;
    while (link_hold && cyc < 20000) begin @(negedge clk); cyc++; end
    chk(!link_hold, "R1 load end", link_hold, 0);
  endtask

  task automatic t_boot_ok;
    int c;
    for (int i = 0; i < 128; i++) begin
      ee[i] = (i == 0) ? 8'hA5 : 8'((i * 37 + 11) & 255);
      img[i] = ee[i];
    end
    reset_and_boot(c);
    chk(cs_rises == 128, "R2 frame count", cs_rises, 128);
    for (int i = 0; i < 128; i++) begin
      @(negedge clk); mem_raddr = 9'(i);
      @(negedge clk);
      chk(mem_rdata == img[i], "R2 R4 image byte", mem_rdata, img[i]);
    end
    repeat (20) @(negedge clk);
    chk(!link_hold && !eecs, "R1 hold stays low", link_hold, 0);
  endtask

  task automatic t_reads;
    read_chk(7'd1, img[1], "R7 read 1");
    read_chk(7'd64, img[64], "R7 read 64");
    read_chk(7'd127, img[127], "R7 R5 read 127");
  endtask

  task automatic t_write_protect;
    int c;
    set_data(8'h5A);
    run_cmd(3'd1, 7'd3, c);
    read_chk(7'd3, img[3], "R12 write before enable");
  endtask

  task automatic t_write;
    int c;
    run_cmd(3'd3, 7'd0, c);
    set_data(8'h5A);
    run_cmd(3'd1, 7'd3, c);
    chk(c > DLY, "R10 waits for ready", c, DLY);
    read_chk(7'd3, 8'h5A, "R8 write then read");
  endtask

  task automatic t_erase;
    int c;
    run_cmd(3'd2, 7'd3, c);
    chk(c > DLY && !timeout, "R10 erase ready wait", c, DLY);
    read_chk(7'd3, 8'hFF, "R12 erase");
  endtask

  task automatic t_busy_ignore;
    int c;
    @(negedge clk);
    cmd_wr = 1; cmd_start = 1; cmd_op = 3'd0; cmd_addr = 7'd5;
    @(negedge clk);
    chk(busy, "R6 busy rises", busy, 1);
    cmd_op = 3'd1; cmd_addr = 7'd6; data_wr = 1; data_wdata = 8'h3C;
    @(negedge clk);
    cmd_wr = 0; cmd_start = 0; data_wr = 0;
    wait_idle(c);
    chk(data_q == img[5], "R9 data write ignored", data_q, img[5]);
    read_chk(7'd6, img[6], "R9 command ignored");
  endtask

  task automatic t_wral_eral;
    int c;
    set_data(8'h77);
    run_cmd(3'd6, 7'd0, c);
    read_chk(7'd0, 8'h77, "R8 R12 wral 0");
    read_chk(7'd100, 8'h77, "R8 R12 wral 100");
    run_cmd(3'd5, 7'd0, c);
    read_chk(7'd50, 8'hFF, "R12 eral");
  endtask

  task automatic t_disable;
    int c;
    run_cmd(3'd4, 7'd0, c);
    set_data(8'h11);
    run_cmd(3'd1, 7'd9, c);
    read_chk(7'd9, 8'hFF, "R12 write after disable");
  endtask

  task automatic t_timeout;
    int c;
    run_cmd(3'd3, 7'd0, c);
    dead = 1;
    set_data(8'h22);
    run_cmd(3'd1, 7'd9, c);
    chk(timeout == 1, "R11 timeout set", timeout, 1);
    chk(!busy && c >= TMO && c < TMO + 100, "R11 timeout length", c, TMO);
    dead = 0;
    read_chk(7'd9, 8'h22, "R7 read after timeout");
    chk(timeout == 0, "R11 timeout cleared", timeout, 0);
  endtask

  task automatic t_bad_code;
    @(negedge clk);
    cmd_wr = 1; cmd_start = 1; cmd_op = 3'd7;
    @(negedge clk);
    cmd_wr = 0; cmd_start = 0;
    chk(!busy, "R6 code 7 ignored", busy, 0);
    repeat (5) @(negedge clk);
    chk(!eecs && !busy, "R6 R5 no frame", eecs, 0);
  endtask

  task automatic t_boot_bad;
    int c;
    for (int i = 0; i < 128; i++) ee[i] = 8'(i);
    reset_and_boot(c);
    chk(cs_rises == 1, "R3 single frame", cs_rises, 1);
    chk(c < 100, "R3 quick abort", c, 100);
    read_chk(7'd20, 8'd20, "R3 host usable");
  endtask

  initial begin
    t_boot_ok();
    t_reads();
    t_write_protect();
    t_write();
    t_erase();
    t_busy_ignore();
    t_wral_eral();
    t_disable();
    t_timeout();
    t_bad_code();
    t_boot_bad();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule